// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block collects a handful of small system-control registers behind one simple synchronous bus. Each register has its own select line. The address, write strobe, write data and read data are shared by all of them. A write takes effect on the clock edge where both the strobe and a select are high. A read is combinational from whichever register is selected.

Besides holding plain values, the bank drives four system-level signals:

- an interrupt for a power-fail condition,
- a one-cycle terminal-count pulse for a floppy controller,
- a one-cycle power-off request,
- a one-cycle system-reset request.

An asynchronous power-fail level from the supply monitor enters through a two-flop synchroniser. A change of that level updates a sticky status bit, which software clears by writing a command bit. The diagnostic and system-control registers are deliberately left untouched by reset, so that software can inspect them after a reset it requested itself.

Top module: `sysaux_regbank`

## Requirements
- R1: The synchronous active-low reset clears these registers to 0: configuration, modem-control, auxiliary-1, auxiliary-2 and the LED register. The diagnostic and system-control registers keep their values across reset, and all pulse outputs are 0 during reset.
- R2: Configuration, diagnostic and modem-control are 8-bit read/write registers. Each is loaded from write data bits 7..0 and reads back zero-extended.
- R3: A write to auxiliary-1 stores write data bits 7..0 with bit 1 forced to 0. When the written bit 1 is 1, `tc_pulse_o` is high for exactly the one cycle after the write edge.
- R4: A write to auxiliary-2 behaves as follows:
  - bit 0 (power-off) is stored from the write data;
  - bits 7..6 and 4..1 are stored as 0;
  - bit 5 (power-fail status) keeps its value, except that a written bit 1 of 1 clears it.
- R5: A write to auxiliary-2 with bit 0 set drives `pwroff_req_o` high for exactly the one cycle after the write edge.
- R6: `pf_in` passes through two synchroniser flops. Whenever the synchronised level changes, the power-fail status becomes (synchronised level AND configuration bit 3), so a change of `pf_in` before edge k shows in the status after edge k+2. If such a change coincides with a clearing write, the change wins.
- R7: `irq_o` equals power-fail status AND configuration bit 3, evaluated from the registers. A configuration write therefore changes it right after the write edge, without altering the status bit.
- R8: The system-control register is 32 bits wide.
  - A write at address 0 with bit 0 set loads 0x00000002 and pulses `sysrst_req_o` for the one cycle after the edge.
  - Writes with bit 0 clear, and writes at any other address, have no effect.
  - Reads at any other address return 0.
- R9: The LED register is 16 bits wide. It is written and read only at address 0; writes elsewhere are ignored and reads elsewhere return 0.
- R10: `bus_sel` bit positions are 0 configuration, 1 diagnostic, 2 modem-control, 3 auxiliary-1, 4 auxiliary-2, 5 LED, 6 system-control. With no select active, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 7 | One select per register (see R10) |
| bus_addr | input | 2 | Byte offset within the selected register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pf_in | input | 1 | Asynchronous power-fail level |
| irq_o | output | 1 | Power-fail interrupt |
| tc_pulse_o | output | 1 | One-cycle terminal-count pulse |
| pwroff_req_o | output | 1 | One-cycle power-off request |
| sysrst_req_o | output | 1 | One-cycle system-reset request |

## Verification
The embedded assertions check, on every cycle, the following:

- every pulse output has a matching write in the previous cycle;
- auxiliary-1 never keeps the pulse bit;
- a clearing write with no coinciding input change empties the power-fail status;
- the status can only rise while the enable is set;
- the interrupt only rises after an input change or an enable rise;
- the system-control register holds between writes.

Other behaviour needs the bench's scenarios against its cycle-level model:

- retention of the diagnostic and system-control values across a second reset;
- the three-edge input latency;
- the priority of an input change over a coincident clear;
- address-gated reads of the LED and system-control registers;
- the interrupt following enable toggles while the status stays put.

// File: rtl/sysaux_pkg.sv
// Package: shared select indices and bit positions for the auxiliary
// system control register bank. Assumes one-hot use of the select vector.
package sysaux_pkg;
    localparam int NUM_SEL     = 7;
    localparam int SEL_CFG     = 0;
    localparam int SEL_DIAG    = 1;
    localparam int SEL_MODEM   = 2;
    localparam int SEL_AUX1    = 3;
    localparam int SEL_AUX2    = 4;
    localparam int SEL_LED     = 5;
    localparam int SEL_SYS     = 6;

    localparam int CFG_PFIE_BIT  = 3;
    localparam int AUX1_TC_BIT   = 1;
    localparam int AUX2_OFF_BIT  = 0;
    localparam int AUX2_CLR_BIT  = 1;
    localparam int AUX2_PF_BIT   = 5;
    localparam int SYS_GO_BIT    = 0;
    localparam int SYS_STAT_BIT  = 1;
endpackage

// File: rtl/sysaux_sync.sv
// Module: multi-stage level synchroniser.
// Assumes STAGES >= 2 and that the input is a slow level, not a pulse.
module sysaux_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/sysaux_rw_reg.sv
// Module: plain read/write register of width W.
// CLEAR_ON_RESET selects whether the synchronous reset clears it or the
// register keeps its contents across reset.
module sysaux_rw_reg #(
    parameter int W              = 8,
    parameter bit CLEAR_ON_RESET = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    generate
        if (CLEAR_ON_RESET) begin : g_clr
            // Load on write, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= '0;
                else if (wr_en) q <= wr_data;
            end
        end else begin : g_keep
            logic unused_rst_n;
            assign unused_rst_n = rst_n;
            // Load on write; reset leaves the value alone.
            always_ff @(posedge clk) begin
                if (wr_en) q <= wr_data;
            end
        end
    endgenerate

    AST_RW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wr_data))) else $error("rw load"); // R2
endmodule

// File: rtl/sysaux_tc_reg.sv
// Module: auxiliary-1 register. The bit at TC_BIT is a command: it is
// turned into a one-cycle pulse and never stored. Other bits store as written.
module sysaux_tc_reg #(
    parameter int W      = 8,
    parameter int TC_BIT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q,
    output logic         tc_pulse
);
    localparam logic [W-1:0] TC_MASK = W'(1) << TC_BIT;

    // Store the written value minus the command bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data & ~TC_MASK;
    end

    // Emit the terminal-count pulse for one cycle after a commanding write.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_pulse <= 1'b0;
        else        tc_pulse <= wr_en && wr_data[TC_BIT];
    end

    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(wr_en && wr_data[TC_BIT])) else $error("tc cause"); // R3
    AST_TC_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q[TC_BIT] == 1'b0 && q[W-1:TC_BIT+1] == $past(wr_data[W-1:TC_BIT+1])))
        else $error("tc kept"); // R3
endmodule

// File: rtl/sysaux_power.sv
// Module: auxiliary-2 power control. Holds the power-off bit and the sticky
// power-fail status, and drives the interrupt and the power-off pulse.
// Assumes pf_sync is already synchronised to clk.
module sysaux_power
    import sysaux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pf_sync,
    input  logic         pf_en,
    input  logic         wr_en,
    input  logic         wr_off,
    input  logic         wr_clr,
    output logic [W-1:0] aux2_q,
    output logic         irq_o,
    output logic         pwroff_o
);
    logic pf_prev_q;
    logic pf_stat_q;
    logic off_q;
    logic pf_event;

    assign pf_event = pf_sync ^ pf_prev_q;

    // Remember the last synchronised level to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) pf_prev_q <= 1'b0;
        else        pf_prev_q <= pf_sync;
    end

    // Status follows a level change when enabled; a clearing write empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)                pf_stat_q <= 1'b0;
        else if (pf_event)         pf_stat_q <= pf_sync & pf_en;
        else if (wr_en && wr_clr)  pf_stat_q <= 1'b0;
    end

    // Power-off bit is stored from every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     off_q <= 1'b0;
        else if (wr_en) off_q <= wr_off;
    end

    // One-cycle power-off request after a write with the off bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pwroff_o <= 1'b0;
        else        pwroff_o <= wr_en && wr_off;
    end

    // Assemble the readable register image.
    always_comb begin
        aux2_q               = '0;
        aux2_q[AUX2_OFF_BIT] = off_q;
        aux2_q[AUX2_PF_BIT]  = pf_stat_q;
    end

    assign irq_o = pf_stat_q & pf_en;

    AST_PWROFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pwroff_o |-> $past(wr_en && wr_off)) else $error("pwroff cause"); // R5
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_clr && !pf_event) |=> !aux2_q[AUX2_PF_BIT]) else $error("clr"); // R4
    AST_STAT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_stat_q) |-> $past(pf_en)) else $error("stat en"); // R6
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(pf_event) || $rose(pf_en))) else $error("irq cause"); // R7
endmodule

// File: rtl/sysaux_sysctl.sv
// Module: system-control register. A go command loads the reset-status
// value and pulses the reset request. Contents survive reset by design.
module sysaux_sysctl
    import sysaux_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_go,
    output logic [W-1:0] q,
    output logic         rst_req
);
    localparam logic [W-1:0] STAT_VAL = W'(1) << SYS_STAT_BIT;

    // Load the status value on a go write; no reset on purpose.
    always_ff @(posedge clk) begin
        if (wr_en && wr_go) q <= STAT_VAL;
    end

    // One-cycle reset request after a go write.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= wr_en && wr_go;
    end

    AST_SYSRST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (q == STAT_VAL)) else $error("sys status"); // R8
    AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_go) |=> $stable(q)) else $error("sys hold"); // R8
endmodule

// File: rtl/sysaux_regbank.sv
// Module: top of the auxiliary system control register bank. Decodes the
// per-register selects, instantiates the registers and muxes read data.
// Assumes at most one select is high at a time; reads are combinational.
module sysaux_regbank
    import sysaux_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int LED_W       = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SEL-1:0]  bus_sel,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                pf_in,
    output logic                irq_o,
    output logic                tc_pulse_o,
    output logic                pwroff_req_o,
    output logic                sysrst_req_o
);
    logic [NUM_SEL-1:0] wr_hit;
    logic               at_base;
    logic [BYTE_W-1:0]  cfg_q, diag_q, modem_q, aux1_q, aux2_q;
    logic [LED_W-1:0]   led_q;
    logic [DATA_W-1:0]  sys_q;
    logic               pf_sync;
    logic               unused_wdata;

    assign wr_hit       = bus_we ? bus_sel : '0;
    assign at_base      = (bus_addr == '0);
    assign unused_wdata = ^bus_wdata[DATA_W-1:LED_W];

    sysaux_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pf_in), .q_out(pf_sync));

    sysaux_rw_reg #(.W(BYTE_W), .CLEAR_ON_RESET(1'b1)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[SEL_CFG]),
        .wr_data(bus_wdata[BYTE_W-1:0]), .q(cfg_q));

    sysaux_rw_reg #(.W(BYTE_W), .CLEAR_ON_RESET(1'b0)) u_diag (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[SEL_DIAG]),
        .wr_data(bus_wdata[BYTE_W-1:0]), .q(diag_q));

    sysaux_rw_reg #(.W(BYTE_W), .CLEAR_ON_RESET(1'b1)) u_modem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[SEL_MODEM]),
        .wr_data(bus_wdata[BYTE_W-1:0]), .q(modem_q));

    sysaux_rw_reg #(.W(LED_W), .CLEAR_ON_RESET(1'b1)) u_led (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[SEL_LED] && at_base),
        .wr_data(bus_wdata[LED_W-1:0]), .q(led_q));

    sysaux_tc_reg #(.W(BYTE_W), .TC_BIT(AUX1_TC_BIT)) u_aux1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[SEL_AUX1]),
        .wr_data(bus_wdata[BYTE_W-1:0]), .q(aux1_q), .tc_pulse(tc_pulse_o));

    sysaux_power #(.W(BYTE_W)) u_power (
        .clk(clk), .rst_n(rst_n), .pf_sync(pf_sync),
        .pf_en(cfg_q[CFG_PFIE_BIT]), .wr_en(wr_hit[SEL_AUX2]),
        .wr_off(bus_wdata[AUX2_OFF_BIT]), .wr_clr(bus_wdata[AUX2_CLR_BIT]),
        .aux2_q(aux2_q), .irq_o(irq_o), .pwroff_o(pwroff_req_o));

    sysaux_sysctl #(.W(DATA_W)) u_sys (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[SEL_SYS] && at_base),
        .wr_go(bus_wdata[SYS_GO_BIT]), .q(sys_q), .rst_req(sysrst_req_o));

    // Read mux: OR of every selected register, address-gated where sized.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel[SEL_CFG])   bus_rdata = bus_rdata | DATA_W'(cfg_q);
        if (bus_sel[SEL_DIAG])  bus_rdata = bus_rdata | DATA_W'(diag_q);
        if (bus_sel[SEL_MODEM]) bus_rdata = bus_rdata | DATA_W'(modem_q);
        if (bus_sel[SEL_AUX1])  bus_rdata = bus_rdata | DATA_W'(aux1_q);
        if (bus_sel[SEL_AUX2])  bus_rdata = bus_rdata | DATA_W'(aux2_q);
        if (bus_sel[SEL_LED] && at_base) bus_rdata = bus_rdata | DATA_W'(led_q);
        if (bus_sel[SEL_SYS] && at_base) bus_rdata = bus_rdata | sys_q;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !(tc_pulse_o || pwroff_req_o || sysrst_req_o || irq_o))
        else $error("reset quiet"); // R1
endmodule

// File: tb/sysaux_regbank_tb_top.sv
// Bench: behavioural cycle model compared with the design after every edge.
module sysaux_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_sel = '0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pf_in = 1'b0;
    logic        irq_o, tc_pulse_o, pwroff_req_o, sysrst_req_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    string note = "";

    always #10 clk = ~clk;

    sysaux_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pf_in(pf_in), .irq_o(irq_o), .tc_pulse_o(tc_pulse_o),
        .pwroff_req_o(pwroff_req_o), .sysrst_req_o(sysrst_req_o));

    // Reference state
    logic [31:0] m_cfg = 0, m_diag = 0, m_modem = 0, m_aux1 = 0, m_led = 0, m_sys = 0;
    bit m_off, m_stat, m_s1, m_s2, m_prev, m_tc, m_poff, m_srst;
    bit diag_known = 0, sys_known = 0;
    bit ev, en;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_modem = 0; m_aux1 = 0; m_led = 0;
            m_off = 0; m_stat = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
            m_tc = 0; m_poff = 0; m_srst = 0;
        end else begin
            ev = (m_s2 != m_prev);
            en = m_cfg[3];
            m_tc = 0; m_poff = 0; m_srst = 0;
            if (ev) m_stat = m_s2 & en;
            else if (bus_we && bus_sel[4] && bus_wdata[1]) m_stat = 0;
            if (bus_we) begin
                if (bus_sel[0]) m_cfg = bus_wdata & 32'hFF;
                if (bus_sel[1]) begin m_diag = bus_wdata & 32'hFF; diag_known = 1; end
                if (bus_sel[2]) m_modem = bus_wdata & 32'hFF;
                if (bus_sel[3]) begin
                    m_aux1 = bus_wdata & 32'hFD;
                    m_tc = bus_wdata[1];
                end
                if (bus_sel[4]) begin
                    m_off = bus_wdata[0];
                    m_poff = bus_wdata[0];
                end
                if (bus_sel[5] && bus_addr == 0) m_led = bus_wdata & 32'hFFFF;
                if (bus_sel[6] && bus_addr == 0 && bus_wdata[0]) begin
                    m_sys = 32'h2; sys_known = 1; m_srst = 1;
                end
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pf_in;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s%s: actual %h expected %h at %0t", tag, note, act, exp, $time);
        end
    endtask

    // Compare every output a few ns after each edge.
    always @(posedge clk) begin
        logic [31:0] exp_rd;
        bit known;
        string tag;
        #5;
        exp_rd = 0; known = 1; tag = "R10 idle read";
        if (bus_sel[0]) begin exp_rd |= m_cfg; tag = "R2 cfg read"; end
        if (bus_sel[1]) begin exp_rd |= m_diag; known &= diag_known; tag = "R2 diag read"; end
        if (bus_sel[2]) begin exp_rd |= m_modem; tag = "R2 modem read"; end
        if (bus_sel[3]) begin exp_rd |= m_aux1; tag = "R3 aux1 read"; end
        if (bus_sel[4]) begin exp_rd |= {26'd0, m_stat, 4'd0, m_off}; tag = "R4 R6 aux2 read"; end
        if (bus_sel[5]) begin if (bus_addr == 0) exp_rd |= m_led; tag = "R9 led read"; end
        if (bus_sel[6]) begin
            if (bus_addr == 0) begin exp_rd |= m_sys; known &= sys_known; end
            tag = "R8 sysctl read";
        end
        if (known) chk(tag, bus_rdata, exp_rd);
        chk("R7 irq", {31'd0, irq_o}, {31'd0, m_stat & m_cfg[3]});
        chk("R3 tc pulse", {31'd0, tc_pulse_o}, {31'd0, m_tc});
        chk("R5 power-off pulse", {31'd0, pwroff_req_o}, {31'd0, m_poff});
        chk("R8 reset pulse", {31'd0, sysrst_req_o}, {31'd0, m_srst});
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int idx, logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = '0; bus_sel[idx] = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(int idx, logic [1:0] a);
        @(negedge clk);
        bus_sel = '0; bus_sel[idx] = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = '0; bus_addr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        note = " (R1 after reset)";
        for (int i = 0; i < 6; i++) if (i != 1) rd(i, 0);
        note = "";
        // R2 plain registers
        wr(0, 0, 32'hFFFF_FFA5); rd(0, 0);
        wr(1, 0, 32'h0000_003C); rd(1, 3);
        wr(2, 0, 32'h1234_565A); rd(2, 0);
        // R3 terminal count
        wr(3, 0, 32'hFF); rd(3, 0);
        wr(3, 0, 32'h40); rd(3, 0);
        wr(3, 0, 32'h02); rd(3, 0);
        // R9 LED
        wr(5, 0, 32'hABCD_BEEF); rd(5, 0);
        wr(5, 1, 32'h1234); rd(5, 0); rd(5, 1);
        // R8 system control
        wr(6, 0, 32'h1); rd(6, 0);
        wr(6, 2, 32'h1); wr(6, 0, 32'hFFFF_FFFE); rd(6, 0); rd(6, 3);
        // R6 R7 power fail
        wr(0, 0, 32'h08);
        @(negedge clk); pf_in = 1'b1;
        idle(4); rd(4, 0);
        wr(4, 0, 32'h02); rd(4, 0);
        @(negedge clk); pf_in = 1'b0; idle(4); rd(4, 0);
        wr(0, 0, 32'h00);
        @(negedge clk); pf_in = 1'b1; idle(4);
        wr(0, 0, 32'h08); rd(4, 0);
        @(negedge clk); pf_in = 1'b0; idle(4);
        @(negedge clk); pf_in = 1'b1; idle(4); rd(4, 0);
        wr(0, 0, 32'h00); rd(4, 0);
        wr(0, 0, 32'h08); rd(4, 0);
        // R4 R5 power-off with clear and merge
        wr(4, 0, 32'h01); rd(4, 0);
        wr(4, 0, 32'hFF); rd(4, 0);
        wr(4, 0, 32'h00); rd(4, 0);
        // R6 input change against coincident clear
        @(negedge clk); pf_in = 1'b0; idle(4);
        @(negedge clk); pf_in = 1'b1;
        @(negedge clk);
        wr(4, 0, 32'h02); rd(4, 0);
        @(negedge clk); pf_in = 1'b0;
        wr(4, 0, 32'h02); rd(4, 0);
        // Back-to-back writes
        @(negedge clk); bus_sel = 7'b0001000; bus_we = 1; bus_wdata = 32'h06;
        @(negedge clk); bus_sel = 7'b0010000; bus_wdata = 32'h01;
        @(negedge clk); bus_sel = 7'b1000000; bus_wdata = 32'h01;
        @(negedge clk); bus_sel = '0; bus_we = 0; bus_wdata = '0;
        idle(2);
        // R1 second reset: retention of diag and sysctl
        wr(5, 0, 32'h5555); wr(2, 0, 32'h77);
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1;
        note = " (R1 second reset)";
        for (int i = 0; i < 7; i++) rd(i, 0);
        note = "";
        idle(3);
        finish_run();
    end
endmodule